// File: doc/BRIEF.md
# Integer Load Formatting Unit

This unit sits between the integer register file and the data memory port of a 32-bit core. For each load it computes the effective address: the base register plus either a sign-extended 16-bit displacement or an index register value. It presents that address to memory. From the aligned 32-bit word that memory returns, it builds the right-justified value for the destination register. The size can be a byte, a halfword or a word. Halfwords can be zero-extended or sign-extended. Halfwords and words can also be byte-reversed.

Update forms also return the effective address as a write-back to the base register. An update form is rejected when its base register is register 0 or is the destination register. The unit flags that request and performs no write-back.

Every form passes through the same two pipeline registers. A result always appears two cycles after its request, and a new request can be accepted every cycle.

Top module: `ld_format_unit`

## Requirements
- R1: In the displacement form (`opIndexed`=0), `memAddr` equals `baseVal` plus `disp` sign-extended to 32 bits. It is visible in the cycle after the request.
- R2: In the indexed form (`opIndexed`=1), `memAddr` equals `baseVal` plus `indexVal`, and `disp` has no effect.
- R3: A byte load (`opSize`=0) returns the addressed byte, zero-extended. Memory is big-endian: address bits [1:0]=0 selects `memData[31:24]` and 3 selects `memData[7:0]`. `opSigned` and `opReverse` have no effect on a byte load.
- R4: A halfword load (`opSize`=1) selects `memData[31:16]` when address bit 1 is 0 and `memData[15:0]` when it is 1. The result is zero-extended when `opSigned`=0 and sign-extended from bit 15 when `opSigned`=1.
- R5: A word load (`opSize`=2, with 3 behaving the same) returns the whole `memData`. It ignores the low address bits and `opSigned`.
- R6: With `opReverse`=1, a halfword load swaps its two bytes before extension. A word load returns its four bytes in reverse order.
- R7: A valid update form (`opUpdate`=1) raises `wbValid` in the same cycle as `resValid`, with `wbIdx`=`baseIdx` and `wbData` equal to the effective address.
- R8: An update form whose `baseIdx` is 0 or equals `dstIdx` raises `badUpdate` with its result and keeps `wbValid` low. The load result is still delivered.
- R9: Reset clears `resValid`, `wbValid` and `badUpdate`. Every request produces `resValid` exactly two cycles later, whatever its form. Back-to-back requests give results on back-to-back cycles, and `dstOut` carries each request's `dstIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| opSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| opSigned | input | 1 | Sign-extend (halfword only) |
| opReverse | input | 1 | Byte-reversed ordering |
| opIndexed | input | 1 | Use index register instead of displacement |
| opUpdate | input | 1 | Write effective address back to base |
| baseIdx | input | 5 | Base register number |
| dstIdx | input | 5 | Destination register number |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register value |
| disp | input | 16 | Signed displacement |
| memAddr | output | 32 | Effective address to memory (stage 1) |
| memData | input | 32 | Aligned memory word for `memAddr`, same cycle |
| resValid | output | 1 | Result valid |
| resData | output | 32 | Formatted destination value |
| dstOut | output | 5 | Destination register of the result |
| wbValid | output | 1 | Base write-back valid |
| wbIdx | output | 5 | Base register to write |
| wbData | output | 32 | Effective address to write back |
| badUpdate | output | 1 | Rejected update form |

## Verification
Two things can land in the same cycle. The first is the load result and the base write-back of one update request. The second is the address of a younger request and the formatted result of an older one. The bench provokes both with a back-to-back stream that mixes update, indexed, reversed and signed forms.

At every output cycle the bench compares the result, the write-back and `dstOut` against values computed from the request that entered two cycles earlier. A mix-up between neighbouring requests, or a write-back taken from the wrong stage, shows up as a mismatch.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  // Strobes and format selects from control to datapath
  typedef struct packed {
    logic  s1Load;     // capture effective address
    logic  s2Load;     // capture formatted result
    logic  useIndex;   // offset from index register
    size_e fmtSize;
    logic  fmtSigned;
    logic  fmtRev;
  } ctl_t;
endpackage

// File: rtl/ldfmt_ctrl.sv
module ldfmt_ctrl
  import ldfmt_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        opSize,
  input  logic              opSigned,
  input  logic              opReverse,
  input  logic              opIndexed,
  input  logic              opUpdate,
  input  logic [REG_AW-1:0] baseIdx,
  input  logic [REG_AW-1:0] dstIdx,
  output ctl_t              ctl,
  output logic              resValid,
  output logic              wbValid,
  output logic [REG_AW-1:0] wbIdx,
  output logic [REG_AW-1:0] dstOut,
  output logic              badUpdate
);
  logic              v1, upd1, bad1, sgn1, rev1;
  size_e             size1;
  logic [REG_AW-1:0] base1, dst1;
  logic              reqBad;

  assign reqBad = opUpdate && ((baseIdx == '0) || (baseIdx == dstIdx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
    end else begin
      v1 <= reqValid;
    end
    if (reqValid) begin
      size1 <= size_e'(opSize);
      sgn1  <= opSigned;
      rev1  <= opReverse;
      upd1  <= opUpdate;
      bad1  <= reqBad;
      base1 <= baseIdx;
      dst1  <= dstIdx;
    end
  end

  always_comb begin
    ctl.s1Load    = reqValid;
    ctl.useIndex  = opIndexed;
    ctl.s2Load    = v1;
    ctl.fmtSize   = size1;
    ctl.fmtSigned = sgn1;
    ctl.fmtRev    = rev1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid  <= 1'b0;
      wbValid   <= 1'b0;
      badUpdate <= 1'b0;
    end else begin
      resValid  <= v1;
      wbValid   <= v1 && upd1 && !bad1;
      badUpdate <= v1 && bad1;
    end
    if (v1) begin
      wbIdx  <= base1;
      dstOut <= dst1;
    end
  end

  // Fixed two-cycle latency for every form
  assert_fixed_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> ##1 resValid);
  // Rejected update never writes back
  assert_no_bad_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    badUpdate |-> !wbValid);
  // Write-back only accompanies a result
  assert_wb_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> resValid);
endmodule

// File: rtl/ldfmt_dpath.sv
module ldfmt_dpath
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] indexVal,
  input  logic [DISP_W-1:0] disp,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] resData,
  output logic [DATA_W-1:0] wbData
);
  localparam int BYTES = DATA_W / 8;
  localparam int HALF  = DATA_W / 2;

  logic [DATA_W-1:0] offset;
  logic [7:0]        laneBe [BYTES];
  logic [DATA_W-1:0] revWord;
  logic [15:0]       halfRaw, halfOrd;
  logic [DATA_W-1:0] fmtData;

  assign offset = ctl.useIndex ? indexVal
                               : {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp};

  always_ff @(posedge clk) begin
    if (!rst_n) memAddr <= '0;
    else if (ctl.s1Load) memAddr <= baseVal + offset;
  end

  // Big-endian byte lanes: lane 0 is the most significant byte
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign laneBe[k] = memData[DATA_W-1-8*k -: 8];
    assign revWord[8*k +: 8] = laneBe[k];
  end

  assign halfRaw = memAddr[1] ? memData[15:0] : memData[DATA_W-1 -: 16];
  assign halfOrd = ctl.fmtRev ? {halfRaw[7:0], halfRaw[15:8]} : halfRaw;

  always_comb begin
    unique case (ctl.fmtSize)
      SZ_BYTE: fmtData = {{(DATA_W-8){1'b0}}, laneBe[memAddr[1:0]]};
      SZ_HALF: fmtData = {{(HALF){ctl.fmtSigned & halfOrd[15]}}, halfOrd};
      default: fmtData = ctl.fmtRev ? revWord : memData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resData <= '0;
      wbData  <= '0;
    end else if (ctl.s2Load) begin
      resData <= fmtData;
      wbData  <= memAddr;
    end
  end

  assert_byte_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.s2Load && ctl.fmtSize == SZ_BYTE) |=> resData[DATA_W-1:8] == '0);
  assert_half_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.s2Load && ctl.fmtSize == SZ_HALF && ctl.fmtSigned)
      |=> resData[DATA_W-1:16] == {(HALF){resData[15]}});
  assert_half_zext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.s2Load && ctl.fmtSize == SZ_HALF && !ctl.fmtSigned)
      |=> resData[DATA_W-1:16] == '0);
endmodule

// File: rtl/ld_format_unit.sv
module ld_format_unit
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        opSize,
  input  logic              opSigned,
  input  logic              opReverse,
  input  logic              opIndexed,
  input  logic              opUpdate,
  input  logic [REG_AW-1:0] baseIdx,
  input  logic [REG_AW-1:0] dstIdx,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] indexVal,
  input  logic [DISP_W-1:0] disp,
  output logic [DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [REG_AW-1:0] dstOut,
  output logic              wbValid,
  output logic [REG_AW-1:0] wbIdx,
  output logic [DATA_W-1:0] wbData,
  output logic              badUpdate
);
  ctl_t ctl;

  ldfmt_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .opSize(opSize),
    .opSigned(opSigned), .opReverse(opReverse), .opIndexed(opIndexed),
    .opUpdate(opUpdate), .baseIdx(baseIdx), .dstIdx(dstIdx), .ctl(ctl),
    .resValid(resValid), .wbValid(wbValid), .wbIdx(wbIdx),
    .dstOut(dstOut), .badUpdate(badUpdate)
  );

  ldfmt_dpath #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .baseVal(baseVal),
    .indexVal(indexVal), .disp(disp), .memData(memData),
    .memAddr(memAddr), .resData(resData), .wbData(wbData)
  );
endmodule

// File: tb/sim_ld_format_unit.sv
module sim_ld_format_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  opSize = '0;
  logic        opSigned = 1'b0, opReverse = 1'b0, opIndexed = 1'b0, opUpdate = 1'b0;
  logic [4:0]  baseIdx = '0, dstIdx = '0;
  logic [31:0] baseVal = '0, indexVal = '0;
  logic [15:0] disp = '0;
  logic [31:0] memAddr, memData, resData, wbData;
  logic        resValid, wbValid, badUpdate;
  logic [4:0]  dstOut, wbIdx;

  int nChk = 0, nBad = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] memFn(logic [31:0] a);
    return 32'h9C3E57F1 ^ {a[31:2], 2'b00};
  endfunction
  assign memData = memFn(memAddr);

  ld_format_unit u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .opSize(opSize),
    .opSigned(opSigned), .opReverse(opReverse), .opIndexed(opIndexed),
    .opUpdate(opUpdate), .baseIdx(baseIdx), .dstIdx(dstIdx),
    .baseVal(baseVal), .indexVal(indexVal), .disp(disp), .memAddr(memAddr),
    .memData(memData), .resValid(resValid), .resData(resData),
    .dstOut(dstOut), .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData),
    .badUpdate(badUpdate)
  );

  function automatic logic [31:0] expEa(logic [31:0] b, logic [31:0] x,
                                        logic [15:0] d, logic ix);
    return ix ? b + x : b + {{16{d[15]}}, d};
  endfunction

  function automatic logic [31:0] expRes(logic [31:0] ea, logic [1:0] sz,
                                         logic sg, logic rv);
    logic [31:0] w = memFn(ea);
    logic [15:0] h;
    if (sz == 2'd0) return (w >> (8 * (3 - ea[1:0]))) & 32'hFF;
    if (sz == 2'd1) begin
      h = ea[1] ? w[15:0] : w[31:16];
      if (rv) h = {h[7:0], h[15:8]};
      return sg ? {{16{h[15]}}, h} : {16'h0, h};
    end
    return rv ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] sz, logic sg, logic rv, logic ix, logic up,
                       logic [4:0] bi, logic [4:0] di, logic [31:0] b,
                       logic [31:0] x, logic [15:0] d);
    reqValid = 1'b1; opSize = sz; opSigned = sg; opReverse = rv;
    opIndexed = ix; opUpdate = up; baseIdx = bi; dstIdx = di;
    baseVal = b; indexVal = x; disp = d;
  endtask

  // One request, checked for address, result, write-back
  task automatic runOne(string req, logic [1:0] sz, logic sg, logic rv,
                        logic ix, logic up, logic [4:0] bi, logic [4:0] di,
                        logic [31:0] b, logic [31:0] x, logic [15:0] d);
    logic [31:0] ea = expEa(b, x, d, ix);
    logic bad = up && (bi == 0 || bi == di);
    drive(sz, sg, rv, ix, up, bi, di, b, x, d);
    @(negedge clk);
    reqValid = 1'b0;
    chk({req, " addr"}, memAddr, ea);
    chk({req, " early valid R9"}, {31'h0, resValid}, 32'h0);
    @(negedge clk);
    chk({req, " valid R9"}, {31'h0, resValid}, 32'h1);
    chk({req, " data"}, resData, expRes(ea, sz, sg, rv));
    chk({req, " dst R9"}, {27'h0, dstOut}, {27'h0, di});
    chk({req, " wbValid R7"}, {31'h0, wbValid}, {31'h0, up && !bad});
    chk({req, " badUpdate R8"}, {31'h0, badUpdate}, {31'h0, bad});
    if (up && !bad) begin
      chk({req, " wbIdx R7"}, {27'h0, wbIdx}, {27'h0, bi});
      chk({req, " wbData R7"}, wbData, ea);
    end
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R9 reset resValid", {31'h0, resValid}, 32'h0);
    chk("R9 reset wbValid", {31'h0, wbValid}, 32'h0);
    chk("R9 reset badUpdate", {31'h0, badUpdate}, 32'h0);
  endtask

  task automatic testAddr();
    runOne("R1 disp pos", 2'd2, 0, 0, 0, 0, 3, 4, 32'h1000, 32'h7777, 16'h0024);
    runOne("R1 disp neg", 2'd2, 0, 0, 0, 0, 3, 4, 32'h1000, 32'h7777, 16'hFFF8);
    runOne("R2 indexed", 2'd2, 0, 0, 1, 0, 3, 4, 32'h2000, 32'h0104, 16'h8000);
  endtask

  task automatic testBytes();
    for (int k = 0; k < 4; k++)
      runOne("R3 byte", 2'd0, k[0], k[1], 0, 0, 1, 2, 32'h400 + k, 0, 16'h0);
  endtask

  task automatic testHalves();
    runOne("R4 half hi zext", 2'd1, 0, 0, 0, 0, 1, 2, 32'h400, 0, 16'h0);
    runOne("R4 half hi sext", 2'd1, 1, 0, 0, 0, 1, 2, 32'h400, 0, 16'h0);
    runOne("R4 half lo sext", 2'd1, 1, 0, 0, 0, 1, 2, 32'h402, 0, 16'h0);
    runOne("R4 half lo zext", 2'd1, 0, 0, 1, 0, 1, 2, 32'h400, 2, 16'h0);
  endtask

  task automatic testWords();
    runOne("R5 word unaligned", 2'd2, 1, 0, 0, 0, 1, 2, 32'h403, 0, 16'h0);
    runOne("R5 size3", 2'd3, 0, 0, 0, 0, 1, 2, 32'h808, 0, 16'h0);
  endtask

  task automatic testReverse();
    runOne("R6 rev half lo", 2'd1, 0, 1, 0, 0, 1, 2, 32'h402, 0, 16'h0);
    runOne("R6 rev half sext", 2'd1, 1, 1, 0, 0, 1, 2, 32'h402, 0, 16'h0);
    runOne("R6 rev word", 2'd2, 0, 1, 0, 0, 1, 2, 32'h40C, 0, 16'h0);
  endtask

  task automatic testUpdate();
    runOne("R7 update disp", 2'd1, 1, 0, 0, 1, 7, 9, 32'h3000, 0, 16'hFFFE);
    runOne("R7 update idx", 2'd0, 0, 0, 1, 1, 12, 5, 32'h3000, 32'h11, 16'h0);
    runOne("R8 base zero", 2'd2, 0, 0, 0, 1, 0, 5, 32'h3000, 0, 16'h4);
    runOne("R8 base eq dst", 2'd2, 0, 1, 1, 1, 6, 6, 32'h3000, 32'h8, 16'h0);
  endtask

  // Back-to-back stream: results overlap younger addresses
  task automatic testStream();
    logic [31:0] eaQ [6];
    logic [1:0]  szQ [6];
    logic        sgQ [6], rvQ [6], upQ [6], bdQ [6];
    logic [4:0]  biQ [6], diQ [6];
    for (int i = 0; i < 6; i++) begin
      szQ[i] = 2'(i % 3); sgQ[i] = i[0]; rvQ[i] = i[1];
      upQ[i] = (i != 1); biQ[i] = (i == 4) ? 5'd0 : 5'(i + 10);
      diQ[i] = 5'(i + 20);
      eaQ[i] = expEa(32'h500 + 32'(i * 36), 32'(i * 3), 16'(i * 5), i[0]);
      bdQ[i] = upQ[i] && biQ[i] == 0;
    end
    for (int i = 0; i < 8; i++) begin
      if (i >= 2) begin
        chk("R9 stream valid", {31'h0, resValid}, 32'h1);
        chk("R9 stream data", resData, expRes(eaQ[i-2], szQ[i-2], sgQ[i-2], rvQ[i-2]));
        chk("R9 stream dst", {27'h0, dstOut}, {27'h0, diQ[i-2]});
        chk("R7 stream wbValid", {31'h0, wbValid}, {31'h0, upQ[i-2] && !bdQ[i-2]});
        chk("R8 stream bad", {31'h0, badUpdate}, {31'h0, bdQ[i-2]});
        if (upQ[i-2] && !bdQ[i-2]) chk("R7 stream wbData", wbData, eaQ[i-2]);
      end
      if (i < 6)
        drive(szQ[i], sgQ[i], rvQ[i], i[0], upQ[i], biQ[i], diQ[i],
              32'h500 + 32'(i * 36), 32'(i * 3), 16'(i * 5));
      else reqValid = 1'b0;
      @(negedge clk);
    end
    chk("R9 stream drained", {31'h0, resValid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testAddr();
    testBytes();
    testHalves();
    testWords();
    testReverse();
    testUpdate();
    testStream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule